// File: doc/BRIEF.md
# Trigger Output and Input Conditioner

This block sits between a trigger crosspoint and the external trigger connectors. On the outgoing side it takes the trigger level the crosspoint has picked and passes it through a two-flop synchronizer. It can then turn each rising edge into a fixed-width pulse. An optional inversion follows, and finally an enable gate. The gate also produces a drive-enable flag, so a pad model can treat the output as high impedance while the path is disabled.

On the incoming side, the block synchronizes the digital result of the external threshold comparator. It can invert that result before passing it on. The comparator itself never inverts, so this control is the only inversion on the input path.

A sync strobe is retimed through a single flop on the system clock before it goes to the backplane. All controls are held in one configuration register that software writes and reads over a simple synchronous port. Every control is false after reset.

Top module: `trig_cond_top`

## Requirements
- R1: After reset, the configuration register at address 0 reads 0, and trig_out_o, trig_oe_o and sync_o are all 0.
- R2: The configuration register sits at address 0. Bit 0 enables the output, bit 1 inverts the output, bit 2 selects pulsed mode and bit 3 inverts the input. Reading address 0 returns these four bits with every higher bit as 0, and reading any other address returns 0. A write takes effect in the cycle after the write strobe is sampled. A write to any other address leaves the register unchanged.
- R3: While the output is disabled, trig_out_o and trig_oe_o are both 0 whatever the trigger input does. While it is enabled, trig_oe_o is 1.
- R4: In level mode with the output enabled, trig_out_o equals the trigger input XOR the output-invert bit. It follows an input change two clock edges later.
- R5: In pulsed mode, a rising edge on the trigger input produces a pulse that is exactly 12 cycles long (120 ns at 100 MHz). The pulse starts three clock edges after the input rises. Holding the input high does not lengthen the pulse.
- R6: A rising edge whose synchronized copy arrives while a pulse is still active is ignored. It neither extends nor restarts the pulse.
- R7: The output-invert bit also applies in pulsed mode. The idle output is then 1 and the pulse is a 12-cycle low.
- R8: trig_in_o equals the comparator input XOR the input-invert bit. It follows an input change two clock edges later, and it does not depend on the output enable.
- R9: sync_o equals sync_i delayed by exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (4) | Configuration address, used for both read and write |
| cfg_wdata | input | DATA_W (8) | Configuration write data |
| cfg_rdata | output | DATA_W (8) | Combinational read data for cfg_addr |
| xpt_trig_i | input | 1 | Trigger level selected by the crosspoint (asynchronous) |
| trig_out_o | output | 1 | Conditioned trigger output |
| trig_oe_o | output | 1 | Output drive enable (0 models high impedance) |
| cmp_i | input | 1 | Digital comparator result from the trigger input (asynchronous) |
| trig_in_o | output | 1 | Conditioned trigger input |
| sync_i | input | 1 | Sync strobe to retime |
| sync_o | output | 1 | Retimed sync strobe toward the backplane |

## Verification
The hardest case to reach from the ports is a second rising edge that arrives while a pulse is still running. Because of the synchronizer, the bench has to reason about where that edge lands inside the pulser, not about when it was applied. The stimulus raises the trigger, drops it five cycles later and raises it again two cycles after that. The second synchronized edge then falls well inside the 12-cycle window. The scoreboard expects the pulse to end exactly 12 cycles after it began. A fresh rising edge after the pulse has ended is then used to show that the pulser re-arms.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;

   // Configuration register layout. Field order is the bit order seen by
   // software: out_en is bit 0, in_inv is bit 3.
   typedef struct packed {
      logic in_inv;      // bit 3
      logic pulse_mode;  // bit 2
      logic out_inv;     // bit 1
      logic out_en;      // bit 0
   } trig_cfg_t;

   localparam int CFG_W = $bits(trig_cfg_t);

   localparam trig_cfg_t CFG_RESET = '{in_inv: 1'b0, pulse_mode: 1'b0,
                                       out_inv: 1'b0, out_en: 1'b0};

endpackage

// File: rtl/trig_cond_regs.sv
module trig_cond_regs
   import trig_cond_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int CFG_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output trig_cfg_t         cfg
);

   localparam logic [ADDR_W-1:0] CFG_SEL = ADDR_W'(CFG_ADDR);

   if (DATA_W <= CFG_W) begin : g_bad_width
      $error("trig_cond_regs: DATA_W must exceed the configuration width");
   end
   if (CFG_ADDR < 0 || CFG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("trig_cond_regs: CFG_ADDR does not fit in ADDR_W");
   end

   logic hit;
   logic unused_wdata_hi;

   assign hit             = (addr == CFG_SEL);
   assign unused_wdata_hi = ^wdata[DATA_W-1:CFG_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= CFG_RESET;
      end else if (we && hit) begin
         cfg <= trig_cfg_t'(wdata[CFG_W-1:0]);
      end
   end

   always_comb begin
      rdata = '0;
      if (hit) begin
         rdata[CFG_W-1:0] = cfg;
      end
   end

   // R2: an accepted write lands in the register one edge later
   assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && hit) |=> (cfg == trig_cfg_t'($past(wdata[CFG_W-1:0]))));

   // R2: writes to any other address leave the register alone
   assert_foreign_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !hit) |=> $stable(cfg));

endmodule

// File: rtl/trig_sync.sv
module trig_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("trig_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= RST_VAL;
         else        chain <= d_i;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/trig_pulser.sv
module trig_pulser #(
   parameter int PULSE_CYCLES = 12,
   localparam int CNT_W = $clog2(PULSE_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic pulse_o
);

   if (PULSE_CYCLES < 2) begin : g_bad_len
      $error("trig_pulser: PULSE_CYCLES must be at least 2");
   end

   localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic             level_q;
   logic             rise;
   logic [CNT_W-1:0] remain;

   assign rise = level_i & ~level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         remain  <= '0;
      end else begin
         level_q <= level_i;
         if (remain != '0) begin
            remain <= remain - ONE;      // active pulse: edges are ignored
         end else if (rise) begin
            remain <= LOAD;
         end
      end
   end

   assign pulse_o = (remain != '0);

   // R5: an edge seen while idle starts a full-length pulse
   assert_pulse_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !pulse_o) |=> (remain == LOAD));

   // R6: a running pulse only counts down, whatever the input does
   assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (remain > ONE) |=> (remain == $past(remain) - ONE));

endmodule

// File: rtl/trig_cond_top.sv
module trig_cond_top
   import trig_cond_pkg::*;
#(
   parameter int ADDR_W        = 4,
   parameter int DATA_W        = 8,
   parameter int CFG_ADDR      = 0,
   parameter int SYNC_STAGES   = 2,
   parameter int CLK_PERIOD_PS = 10000,
   parameter int PULSE_CYCLES  = 12,
   parameter int MIN_PULSE_PS  = 80000,
   parameter int MAX_PULSE_PS  = 160000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              xpt_trig_i,
   output logic              trig_out_o,
   output logic              trig_oe_o,
   input  logic              cmp_i,
   output logic              trig_in_o,
   input  logic              sync_i,
   output logic              sync_o
);

   localparam int PULSE_PS = PULSE_CYCLES * CLK_PERIOD_PS;

   if (PULSE_PS < MIN_PULSE_PS || PULSE_PS > MAX_PULSE_PS) begin : g_bad_pulse
      $error("trig_cond_top: pulse length falls outside the allowed window");
   end

   trig_cfg_t cfg;
   logic      xpt_s;
   logic      cmp_s;
   logic      pulse;
   logic      shaped;

   trig_cond_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CFG_ADDR (CFG_ADDR)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .cfg   (cfg)
   );

   // outgoing path
   trig_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_xpt_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (xpt_trig_i),
      .q_o   (xpt_s)
   );

   trig_pulser #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulser (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (xpt_s),
      .pulse_o (pulse)
   );

   assign shaped     = cfg.pulse_mode ? pulse : xpt_s;
   assign trig_out_o = cfg.out_en & (shaped ^ cfg.out_inv);
   assign trig_oe_o  = cfg.out_en;

   // incoming path
   trig_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cmp_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cmp_i),
      .q_o   (cmp_s)
   );

   assign trig_in_o = cmp_s ^ cfg.in_inv;

   // sync retiming
   trig_sync #(.STAGES(1), .RST_VAL(1'b0)) u_sync_ff (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sync_i),
      .q_o   (sync_o)
   );

   // R3: a disabled output is quiet and not driven
   assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.out_en |-> (!trig_out_o && !trig_oe_o));

   // R9: the sync strobe is delayed by exactly one edge
   assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (sync_o == $past(sync_i)));

endmodule

// File: tb/trig_cond_top_tb.sv
module trig_cond_top_tb;

   localparam int SIG_OUT  = 0;
   localparam int SIG_OE   = 1;
   localparam int SIG_IN   = 2;
   localparam int SIG_SYNC = 3;
   localparam int SIG_RD   = 4;

   typedef struct {
      int    cyc;
      int    sig;
      int    val;
      string req;
   } sb_item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       xpt_trig_i = 1'b0;
   logic       trig_out_o;
   logic       trig_oe_o;
   logic       cmp_i = 1'b0;
   logic       trig_in_o;
   logic       sync_i = 1'b0;
   logic       sync_o;

   int       cyc = 0;
   int       checks = 0;
   int       fails = 0;
   bit       done = 1'b0;
   sb_item_t sb[$];

   always #4 clk = ~clk;   // 125 MHz

   always @(posedge clk) cyc <= cyc + 1;

   trig_cond_top u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .xpt_trig_i (xpt_trig_i),
      .trig_out_o (trig_out_o),
      .trig_oe_o  (trig_oe_o),
      .cmp_i      (cmp_i),
      .trig_in_o  (trig_in_o),
      .sync_i     (sync_i),
      .sync_o     (sync_o)
   );

   function automatic int sample(int sig);
      case (sig)
         SIG_OUT:  return int'(trig_out_o);
         SIG_OE:   return int'(trig_oe_o);
         SIG_IN:   return int'(trig_in_o);
         SIG_SYNC: return int'(sync_o);
         default:  return int'(cfg_rdata);
      endcase
   endfunction

   function automatic string sig_name(int sig);
      case (sig)
         SIG_OUT:  return "trig_out_o";
         SIG_OE:   return "trig_oe_o";
         SIG_IN:   return "trig_in_o";
         SIG_SYNC: return "sync_o";
         default:  return "cfg_rdata";
      endcase
   endfunction

   // driver side: queue an expectation "off" negedges from now, kept sorted
   task automatic expect_at(int off, int sig, int val, string req);
      sb_item_t it;
      int pos;
      it.cyc = cyc + off;
      it.sig = sig;
      it.val = val;
      it.req = req;
      pos = sb.size();
      for (int i = 0; i < sb.size(); i++) begin
         if (sb[i].cyc > it.cyc) begin
            pos = i;
            break;
         end
      end
      sb.insert(pos, it);
   endtask

   // monitor: compare due items at the falling edge
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
         sb_item_t it;
         int act;
         it = sb.pop_front();
         act = sample(it.sig);
         checks++;
         if (it.cyc != cyc || act != it.val) begin
            fails++;
            $display("FAIL %s %s cyc=%0d actual=%0d expected=%0d",
                     it.req, sig_name(it.sig), it.cyc, act, it.val);
         end
      end
   end

   task automatic step(int n = 1);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] d);
      cfg_we    = 1'b1;
      cfg_addr  = a;
      cfg_wdata = d;
      step();
      cfg_we    = 1'b0;
      cfg_addr  = 4'd0;
   endtask

   // one rising edge in pulsed mode, expected polarity pol during the pulse
   task automatic pulse_expect(int pol, string req);
      for (int k = 0; k <= 18; k++) begin
         expect_at(k, SIG_OUT, (k >= 3 && k <= 14) ? pol : 1 - pol, req);
      end
   endtask

   initial begin
      xpt_trig_i = 1'b1;
      step(4);
      rst_n = 1'b1;
      // R1: reset state
      expect_at(0, SIG_RD,   0, "R1");
      expect_at(0, SIG_OUT,  0, "R1");
      expect_at(0, SIG_OE,   0, "R1");
      expect_at(0, SIG_SYNC, 0, "R1");
      step(2);

      // R3: disabled output stays quiet while the trigger toggles
      xpt_trig_i = 1'b0;
      for (int k = 0; k < 5; k++) begin
         expect_at(k, SIG_OUT, 0, "R3");
         expect_at(k, SIG_OE,  0, "R3");
      end
      step(2);
      xpt_trig_i = 1'b1;
      step(5);

      // R2: register layout, masking and foreign address
      wr(4'd0, 8'hFF);
      expect_at(0, SIG_RD, 8'h0F, "R2");
      step();
      wr(4'd1, 8'h00);
      expect_at(0, SIG_RD, 8'h0F, "R2");
      step();
      cfg_addr = 4'd5;
      expect_at(0, SIG_RD, 0, "R2");
      step();
      cfg_addr = 4'd0;
      wr(4'd0, 8'h00);
      expect_at(0, SIG_RD, 0, "R2");
      step();

      // R4: level mode, plain then inverted
      wr(4'd0, 8'h01);
      expect_at(0, SIG_OUT, 1, "R4");
      expect_at(0, SIG_OE,  1, "R3");
      step();
      xpt_trig_i = 1'b0;
      expect_at(1, SIG_OUT, 1, "R4");
      expect_at(2, SIG_OUT, 0, "R4");
      step(3);
      xpt_trig_i = 1'b1;
      expect_at(1, SIG_OUT, 0, "R4");
      expect_at(2, SIG_OUT, 1, "R4");
      step(3);
      wr(4'd0, 8'h03);
      expect_at(0, SIG_OUT, 0, "R4");
      step();
      xpt_trig_i = 1'b0;
      expect_at(2, SIG_OUT, 1, "R4");
      step(3);

      // R3: disabling mid-stream silences the output
      wr(4'd0, 8'h02);
      expect_at(0, SIG_OUT, 0, "R3");
      expect_at(0, SIG_OE,  0, "R3");
      step(3);

      // R5: pulsed mode, input held high past the pulse
      wr(4'd0, 8'h05);
      step(4);
      xpt_trig_i = 1'b1;
      pulse_expect(1, "R5");
      step(20);
      xpt_trig_i = 1'b0;
      step(4);

      // R6: second edge lands inside the active pulse
      xpt_trig_i = 1'b1;
      pulse_expect(1, "R6");
      expect_at(20, SIG_OUT, 0, "R6");
      step(5);
      xpt_trig_i = 1'b0;
      step(2);
      xpt_trig_i = 1'b1;
      step(16);
      xpt_trig_i = 1'b0;
      step(4);

      // R5: pulser re-arms for a fresh edge after the pulse
      xpt_trig_i = 1'b1;
      pulse_expect(1, "R5");
      step(3);
      xpt_trig_i = 1'b0;
      step(19);

      // R7: inverted pulse
      wr(4'd0, 8'h07);
      expect_at(0, SIG_OUT, 1, "R7");
      step(2);
      xpt_trig_i = 1'b1;
      pulse_expect(0, "R7");
      step(20);
      xpt_trig_i = 1'b0;
      step(4);

      // R8: input path, plain then inverted, output disabled
      wr(4'd0, 8'h00);
      cmp_i = 1'b1;
      expect_at(1, SIG_IN, 0, "R8");
      expect_at(2, SIG_IN, 1, "R8");
      step(3);
      wr(4'd0, 8'h08);
      expect_at(0, SIG_IN, 0, "R8");
      expect_at(0, SIG_OE, 0, "R8");
      step();
      cmp_i = 1'b0;
      expect_at(1, SIG_IN, 0, "R8");
      expect_at(2, SIG_IN, 1, "R8");
      step(3);

      // R9: sync retiming
      sync_i = 1'b1;
      expect_at(0, SIG_SYNC, 0, "R9");
      expect_at(1, SIG_SYNC, 1, "R9");
      step();
      sync_i = 1'b0;
      expect_at(1, SIG_SYNC, 0, "R9");
      step();
      sync_i = 1'b1;
      expect_at(1, SIG_SYNC, 1, "R9");
      step();
      sync_i = 1'b0;
      step(2);

      while (sb.size() != 0) step();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule